// File: doc/BRIEF.md
# Dataflow ALU Execution Tile

This block is one compute tile of a two-dimensional array of ALUs. When a block of code is mapped onto the array, each of the eight instruction slots in the tile is written with an opcode, a mask of required sources and up to two destinations. After that, nothing fetches or sequences instructions. A slot fires when every source it needs is present in its operand buffers. Its 32-bit result goes straight to the consumer slots named in its destinations.

A destination that names this tile's own coordinates is written back into the local operand buffers over an internal bypass. Any other destination leaves as one operand message on the network output, one message per cycle, carrying the destination coordinates, slot, operand index and data.

The tile works in one of two modes. In block mode, a slot fires once per mapping. In resident mode, a slot stays loaded and re-arms after each firing, so a loop body can run over many iterations without being reloaded. A flush input discards the mapped block in one cycle.

Top module: `dataflow_tile`

## Requirements
- R1: After reset, and after a slot load, no message is pending, `collide_err` is low and the loaded slot holds no operands. A load on `ld_valid` writes the opcode, the required-source mask `ld_req` and both destinations, and arms the slot. In `ld_req`, bit 0 means operand A is required and bit 1 means operand B is required.
- R2: A slot issues only when every source that `ld_req` marks is present. A source that is not required reads as zero.
- R3: At most one slot issues per cycle. Among ready slots, the lowest slot number wins, and the others wait for later cycles.
- R4: The opcode encodings are 0 add, 1 sub (A−B), 2 and, 3 or, 4 xor, 5 shift left A by B[4:0], 6 logical shift right A by B[4:0], and 7 signed A<B giving 1 or 0.
- R5: A destination word is 11 bits: bit 10 enable, bits 9:7 tile x, bits 6:4 tile y, bits 3:1 slot, bit 0 operand index (0 = A, 1 = B). The result of a slot that issues in cycle N appears on the network output after the clock edge that ends cycle N. When both destinations are remote, destination 0 is sent first and destination 1 in the following accepted cycle.
- R6: A destination whose x and y equal the tile's own coordinates is delivered over the bypass and never appears on the network output. The consumer can issue in the cycle after the producer.
- R7: While `res_valid` is high and `res_ready` is low, the message stays unchanged. No slot issues while the held result would have nowhere to go.
- R8: With `resident` low, a slot that has fired does not fire again until it is reloaded, even if new operands arrive.
- R9: With `resident` high, firing clears both operand-present flags and keeps the slot armed. The slot fires again once a fresh set of required operands arrives.
- R10: If a bypass write and an incoming operand on `opin_*` target the same slot and operand index in the same cycle, `collide_err` pulses high for one cycle after that edge, and the bypass value is the one kept.
- R11: A cycle with `flush` high disarms every slot, clears every operand-present and done flag, and drops any pending network message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush | input | 1 | Discard the mapped block |
| resident | input | 1 | 1 = slots re-arm after firing |
| ld_valid | input | 1 | Slot load strobe |
| ld_slot | input | 3 | Slot being loaded |
| ld_op | input | 3 | Opcode (R4 encoding) |
| ld_req | input | 2 | Required sources: bit 0 A, bit 1 B |
| ld_tgt0 | input | 11 | Destination 0 (R5 layout) |
| ld_tgt1 | input | 11 | Destination 1 (R5 layout) |
| opin_valid | input | 1 | Incoming operand strobe |
| opin_slot | input | 3 | Slot the operand is for |
| opin_idx | input | 1 | 0 = operand A, 1 = operand B |
| opin_data | input | 32 | Operand value |
| res_valid | output | 1 | Outgoing operand message valid |
| res_ready | input | 1 | Network accepts the message |
| res_x | output | 3 | Destination tile x |
| res_y | output | 3 | Destination tile y |
| res_slot | output | 3 | Destination slot |
| res_idx | output | 1 | Destination operand index |
| res_data | output | 32 | Result value |
| collide_err | output | 1 | Bypass and incoming operand collided |

## Verification
An operand that lands at edge E can make its slot issue in the cycle after E, and the remote result is then visible after edge E+1. A bypassed operand adds one more edge per hop, and a collision flag appears after the edge where the two writes met. The bench drives inputs and samples outputs only at falling edges. It counts edges from the last stimulus to the one where each result is due, and checks at that point. It also checks for silence on the network output at each earlier falling edge, so a result that arrives early or late is caught as well as a wrong one.

// File: rtl/dft_pkg.sv
package dft_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6,
    OP_SLT = 3'd7
  } op_e;
endpackage

// File: rtl/dft_alu.sv
module dft_alu
  import dft_pkg::*;
#(
  parameter int DW = 32
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  localparam int SHW = $clog2(DW);

  always_comb begin
    unique case (op)
      OP_ADD: y = a + b;
      OP_SUB: y = a - b;
      OP_AND: y = a & b;
      OP_OR:  y = a | b;
      OP_XOR: y = a ^ b;
      OP_SHL: y = a << b[SHW-1:0];
      OP_SHR: y = a >> b[SHW-1:0];
      default: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
    endcase
  end
endmodule

// File: rtl/dft_pick.sv
module dft_pick #(
  parameter int N  = 8,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [SW-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] win;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign win[i]    = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i]) idx = idx | SW'(i);
    end
  end
endmodule

// File: rtl/dft_slots.sv
module dft_slots
  import dft_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int DW    = 32,
  parameter int TW    = 11,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 resident,
  input  logic                 ld_en,
  input  logic [SW-1:0]        ld_slot,
  input  op_e                  ld_op,
  input  logic [1:0]           ld_req,
  input  logic [TW-1:0]        ld_t0,
  input  logic [TW-1:0]        ld_t1,
  input  logic                 wr_en,
  input  logic [SW-1:0]        wr_slot,
  input  logic                 wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic [1:0]           byp_en,
  input  logic [1:0][SW-1:0]   byp_slot,
  input  logic [1:0]           byp_idx,
  input  logic [DW-1:0]        byp_data,
  input  logic                 fire_en,
  input  logic [SW-1:0]        fire_slot,
  output logic [SLOTS-1:0]     ready,
  output op_e                  sel_op,
  output logic [DW-1:0]        sel_a,
  output logic [DW-1:0]        sel_b,
  output logic [TW-1:0]        sel_t0,
  output logic [TW-1:0]        sel_t1
);
  logic [SLOTS-1:0] vld_q, vld_d, done_q, done_d, pa_q, pa_d, pb_q, pb_d;
  op_e              op_q  [SLOTS];
  op_e              op_d  [SLOTS];
  logic [1:0]       req_q [SLOTS];
  logic [1:0]       req_d [SLOTS];
  logic [DW-1:0]    a_q   [SLOTS];
  logic [DW-1:0]    a_d   [SLOTS];
  logic [DW-1:0]    b_q   [SLOTS];
  logic [DW-1:0]    b_d   [SLOTS];
  logic [TW-1:0]    t0_q  [SLOTS];
  logic [TW-1:0]    t0_d  [SLOTS];
  logic [TW-1:0]    t1_q  [SLOTS];
  logic [TW-1:0]    t1_d  [SLOTS];

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      vld_d[s]  = vld_q[s];
      done_d[s] = done_q[s];
      pa_d[s]   = pa_q[s];
      pb_d[s]   = pb_q[s];
      op_d[s]   = op_q[s];
      req_d[s]  = req_q[s];
      a_d[s]    = a_q[s];
      b_d[s]    = b_q[s];
      t0_d[s]   = t0_q[s];
      t1_d[s]   = t1_q[s];
      // firing: re-arm in resident mode, retire in block mode
      if (fire_en && fire_slot == SW'(s)) begin
        if (resident) begin
          pa_d[s] = 1'b0;
          pb_d[s] = 1'b0;
        end else begin
          done_d[s] = 1'b1;
        end
      end
      // incoming network operand
      if (wr_en && wr_slot == SW'(s)) begin
        if (wr_idx) begin pb_d[s] = 1'b1; b_d[s] = wr_data; end
        else        begin pa_d[s] = 1'b1; a_d[s] = wr_data; end
      end
      // local bypass writes take precedence over the network operand
      for (int k = 0; k < 2; k++) begin
        if (byp_en[k] && byp_slot[k] == SW'(s)) begin
          if (byp_idx[k]) begin pb_d[s] = 1'b1; b_d[s] = byp_data; end
          else            begin pa_d[s] = 1'b1; a_d[s] = byp_data; end
        end
      end
      if (ld_en && ld_slot == SW'(s)) begin
        vld_d[s]  = 1'b1;
        done_d[s] = 1'b0;
        pa_d[s]   = 1'b0;
        pb_d[s]   = 1'b0;
        op_d[s]   = ld_op;
        req_d[s]  = ld_req;
        t0_d[s]   = ld_t0;
        t1_d[s]   = ld_t1;
      end
      if (flush) begin
        vld_d[s]  = 1'b0;
        done_d[s] = 1'b0;
        pa_d[s]   = 1'b0;
        pb_d[s]   = 1'b0;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      ready[s] = vld_q[s] & ~done_q[s] &
                 (pa_q[s] | ~req_q[s][0]) & (pb_q[s] | ~req_q[s][1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      done_q <= '0;
      pa_q   <= '0;
      pb_q   <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        op_q[s]  <= OP_ADD;
        req_q[s] <= '0;
        a_q[s]   <= '0;
        b_q[s]   <= '0;
        t0_q[s]  <= '0;
        t1_q[s]  <= '0;
      end
    end else begin
      vld_q  <= vld_d;
      done_q <= done_d;
      pa_q   <= pa_d;
      pb_q   <= pb_d;
      for (int s = 0; s < SLOTS; s++) begin
        op_q[s]  <= op_d[s];
        req_q[s] <= req_d[s];
        a_q[s]   <= a_d[s];
        b_q[s]   <= b_d[s];
        t0_q[s]  <= t0_d[s];
        t1_q[s]  <= t1_d[s];
      end
    end
  end

  assign sel_op = op_q[fire_slot];
  assign sel_a  = req_q[fire_slot][0] ? a_q[fire_slot] : '0;
  assign sel_b  = req_q[fire_slot][1] ? b_q[fire_slot] : '0;
  assign sel_t0 = t0_q[fire_slot];
  assign sel_t1 = t1_q[fire_slot];
endmodule

// File: rtl/dft_outq.sv
module dft_outq #(
  parameter int DW = 32,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_rem0,
  input  logic          push_rem1,
  input  logic [PW-1:0] push_t0,
  input  logic [PW-1:0] push_t1,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [PW-1:0] out_tgt,
  output logic [DW-1:0] out_data,
  output logic          can_accept
);
  logic          p0_q, p0_d, p1_q, p1_d;
  logic [PW-1:0] t0_q, t0_d, t1_q, t1_d;
  logic [DW-1:0] d_q, d_d;
  logic          send;

  assign out_valid  = p0_q | p1_q;
  assign out_tgt    = p0_q ? t0_q : t1_q;
  assign out_data   = d_q;
  assign send       = out_valid & out_ready;
  // room for a new result: empty, or last message leaving this cycle
  assign can_accept = ~out_valid | (out_ready & (p0_q ^ p1_q));

  always_comb begin
    p0_d = p0_q;
    p1_d = p1_q;
    t0_d = t0_q;
    t1_d = t1_q;
    d_d  = d_q;
    if (send) begin
      if (p0_q) p0_d = 1'b0;
      else      p1_d = 1'b0;
    end
    if (push) begin
      p0_d = push_rem0;
      p1_d = push_rem1;
      t0_d = push_t0;
      t1_d = push_t1;
      d_d  = push_data;
    end
    if (flush) begin
      p0_d = 1'b0;
      p1_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_q <= 1'b0;
      p1_q <= 1'b0;
      t0_q <= '0;
      t1_q <= '0;
      d_q  <= '0;
    end else begin
      p0_q <= p0_d;
      p1_q <= p1_d;
      if (push) begin
        t0_q <= t0_d;
        t1_q <= t1_d;
        d_q  <= d_d;
      end
    end
  end
endmodule

// File: rtl/dataflow_tile.sv
module dataflow_tile
  import dft_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int DW    = 32,
  parameter int XW    = 3,
  parameter int YW    = 3,
  parameter logic [XW-1:0] TILE_X = 1,
  parameter logic [YW-1:0] TILE_Y = 2,
  localparam int SW   = $clog2(SLOTS),
  localparam int PW   = XW + YW + SW + 1,
  localparam int TW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          resident,
  input  logic          ld_valid,
  input  logic [SW-1:0] ld_slot,
  input  logic [2:0]    ld_op,
  input  logic [1:0]    ld_req,
  input  logic [TW-1:0] ld_tgt0,
  input  logic [TW-1:0] ld_tgt1,
  input  logic          opin_valid,
  input  logic [SW-1:0] opin_slot,
  input  logic          opin_idx,
  input  logic [DW-1:0] opin_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [XW-1:0] res_x,
  output logic [YW-1:0] res_y,
  output logic [SW-1:0] res_slot,
  output logic          res_idx,
  output logic [DW-1:0] res_data,
  output logic          collide_err
);
  logic [SLOTS-1:0]   ready;
  logic               any_ready, can_accept, fire;
  logic [SW-1:0]      pick;
  op_e                sel_op;
  logic [DW-1:0]      sel_a, sel_b, alu_y;
  logic [TW-1:0]      sel_t [2];
  logic [1:0]         is_local, is_remote;
  logic [1:0]         byp_en;
  logic [1:0][SW-1:0] byp_slot;
  logic [1:0]         byp_idx;
  logic [PW-1:0]      out_tgt;
  logic               err_d, err_q;

  dft_pick #(.N(SLOTS)) u_pick (
    .req (ready),
    .any (any_ready),
    .idx (pick)
  );

  assign fire = any_ready & can_accept & ~flush;

  dft_slots #(.SLOTS(SLOTS), .DW(DW), .TW(TW)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .resident (resident),
    .ld_en    (ld_valid),
    .ld_slot  (ld_slot),
    .ld_op    (op_e'(ld_op)),
    .ld_req   (ld_req),
    .ld_t0    (ld_tgt0),
    .ld_t1    (ld_tgt1),
    .wr_en    (opin_valid),
    .wr_slot  (opin_slot),
    .wr_idx   (opin_idx),
    .wr_data  (opin_data),
    .byp_en   (byp_en),
    .byp_slot (byp_slot),
    .byp_idx  (byp_idx),
    .byp_data (alu_y),
    .fire_en  (fire),
    .fire_slot(pick),
    .ready    (ready),
    .sel_op   (sel_op),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .sel_t0   (sel_t[0]),
    .sel_t1   (sel_t[1])
  );

  dft_alu #(.DW(DW)) u_alu (
    .op (sel_op),
    .a  (sel_a),
    .b  (sel_b),
    .y  (alu_y)
  );

  for (genvar k = 0; k < 2; k++) begin : g_dest
    logic hit;
    assign is_local[k]  = sel_t[k][TW-1] &&
                          sel_t[k][PW-1 -: XW] == TILE_X &&
                          sel_t[k][PW-1-XW -: YW] == TILE_Y;
    assign is_remote[k] = sel_t[k][TW-1] & ~is_local[k];
    assign byp_en[k]    = fire & is_local[k];
    assign byp_slot[k]  = sel_t[k][SW:1];
    assign byp_idx[k]   = sel_t[k][0];
  end

  dft_outq #(.DW(DW), .PW(PW)) u_outq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (fire),
    .push_data (alu_y),
    .push_rem0 (is_remote[0]),
    .push_rem1 (is_remote[1]),
    .push_t0   (sel_t[0][PW-1:0]),
    .push_t1   (sel_t[1][PW-1:0]),
    .out_ready (res_ready),
    .out_valid (res_valid),
    .out_tgt   (out_tgt),
    .out_data  (res_data),
    .can_accept(can_accept)
  );

  assign res_x    = out_tgt[PW-1 -: XW];
  assign res_y    = out_tgt[PW-1-XW -: YW];
  assign res_slot = out_tgt[SW:1];
  assign res_idx  = out_tgt[0];

  always_comb begin
    err_d = 1'b0;
    for (int k = 0; k < 2; k++) begin
      if (opin_valid && byp_en[k] && byp_slot[k] == opin_slot && byp_idx[k] == opin_idx)
        err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign collide_err = err_q;
endmodule

// File: rtl/dft_tile_chk.sv
module dft_tile_chk #(
  parameter int DW = 32,
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int SW = 3,
  parameter logic [XW-1:0] TILE_X = 1,
  parameter logic [YW-1:0] TILE_Y = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          opin_valid,
  input logic          res_valid,
  input logic          res_ready,
  input logic [XW-1:0] res_x,
  input logic [YW-1:0] res_y,
  input logic [SW-1:0] res_slot,
  input logic          res_idx,
  input logic [DW-1:0] res_data,
  input logic          collide_err
);
  // R7: a stalled message is held unchanged
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !flush) |=>
      (res_valid && $stable(res_data) && $stable(res_x) && $stable(res_y) &&
       $stable(res_slot) && $stable(res_idx)));

  // R11: flush drops pending messages
  a_r11_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !res_valid);

  // R10: a collision flag always follows an incoming operand
  a_r10_err_after_operand: assert property (@(posedge clk) disable iff (!rst_n)
    collide_err |-> $past(opin_valid));

  // R6: local destinations never reach the network
  a_r6_no_local_msg: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_x == TILE_X && res_y == TILE_Y));

  // R5: an outgoing message carries defined data
  a_r5_msg_known: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !$isunknown({res_data, res_x, res_y, res_slot, res_idx}));
endmodule

bind dataflow_tile dft_tile_chk #(
  .DW(DW), .XW(XW), .YW(YW), .SW(SW), .TILE_X(TILE_X), .TILE_Y(TILE_Y)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .opin_valid (opin_valid),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_x      (res_x),
  .res_y      (res_y),
  .res_slot   (res_slot),
  .res_idx    (res_idx),
  .res_data   (res_data),
  .collide_err(collide_err)
);

// File: tb/tb_dataflow_tile.sv
`timescale 1ns/1ps
module tb_dataflow_tile;
  localparam int TW = 11;

  logic        clk, rst_n, flush, resident;
  logic        ld_valid;
  logic [2:0]  ld_slot, ld_op;
  logic [1:0]  ld_req;
  logic [TW-1:0] ld_tgt0, ld_tgt1;
  logic        opin_valid, opin_idx;
  logic [2:0]  opin_slot;
  logic [31:0] opin_data;
  logic        res_valid, res_ready, res_idx, collide_err;
  logic [2:0]  res_x, res_y, res_slot;
  logic [31:0] res_data;

  int errs = 0;
  int checks = 0;

  dataflow_tile dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .resident(resident),
    .ld_valid(ld_valid), .ld_slot(ld_slot), .ld_op(ld_op), .ld_req(ld_req),
    .ld_tgt0(ld_tgt0), .ld_tgt1(ld_tgt1),
    .opin_valid(opin_valid), .opin_slot(opin_slot), .opin_idx(opin_idx),
    .opin_data(opin_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_x(res_x), .res_y(res_y),
    .res_slot(res_slot), .res_idx(res_idx), .res_data(res_data),
    .collide_err(collide_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] ref_alu(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return a << b[4:0];
      6: return a >> b[4:0];
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  function automatic logic [TW-1:0] tgt(int x, int y, int s, int i);
    return {1'b1, 3'(x), 3'(y), 3'(s), 1'(i)};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load(int s, int op, logic [1:0] req, logic [TW-1:0] t0, logic [TW-1:0] t1);
    ld_valid = 1'b1; ld_slot = 3'(s); ld_op = 3'(op); ld_req = req;
    ld_tgt0 = t0; ld_tgt1 = t1;
    tick();
    ld_valid = 1'b0;
  endtask

  task automatic send(int s, int i, logic [31:0] d);
    opin_valid = 1'b1; opin_slot = 3'(s); opin_idx = 1'(i); opin_data = d;
    tick();
    opin_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    tick();
    flush = 1'b0;
  endtask

  task automatic chk_msg(string tag, int x, int y, int s, int i, logic [31:0] d);
    chk(res_valid === 1'b1, tag, 64'(res_valid), 64'd1);
    chk({res_x, res_y, res_slot, res_idx, res_data} === {3'(x), 3'(y), 3'(s), 1'(i), d},
        tag, {res_x, res_y, res_slot, res_idx, res_data},
        {3'(x), 3'(y), 3'(s), 1'(i), d});
  endtask

  task automatic chk_quiet(string tag);
    chk(res_valid === 1'b0, tag, 64'(res_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] a, b, a2, a5, a7, v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; flush = 1'b0; resident = 1'b0; ld_valid = 1'b0;
    ld_slot = '0; ld_op = '0; ld_req = '0; ld_tgt0 = '0; ld_tgt1 = '0;
    opin_valid = 1'b0; opin_slot = '0; opin_idx = 1'b0; opin_data = '0;
    res_ready = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk_quiet("R1 reset no message");
    chk(collide_err === 1'b0, "R1 reset no error", 64'(collide_err), 64'd0);

    // R4 R5 R2: random operations to remote destinations
    for (int n = 0; n < 60; n++) begin
      int op, x, y, ds, di;
      op = $urandom % 8;
      a = $urandom; b = $urandom;
      if (n % 7 == 0) b = 32'hFFFF_FFF0 + (n % 16);
      x = $urandom % 8; y = $urandom % 8;
      if (x == 1 && y == 2) y = 3;
      ds = $urandom % 8; di = $urandom % 2;
      load(0, op, 2'b11, tgt(x, y, ds, di), '0);
      if ($urandom % 2 == 1) begin send(0, 0, a); send(0, 1, b); end
      else                   begin send(0, 1, b); send(0, 0, a); end
      chk_quiet("R2 no issue with one operand");
      tick();
      chk_msg("R4 R5 alu result", x, y, ds, di, ref_alu(op, a, b));
      tick();
      chk_quiet("R5 message drained");
    end
    do_flush();

    // R3 R6: bypass makes two slots ready together, lowest wins
    a2 = $urandom; a5 = $urandom; a7 = $urandom;
    load(2, 0, 2'b11, tgt(3, 3, 1, 0), '0);
    load(5, 1, 2'b11, tgt(4, 4, 2, 1), '0);
    load(7, 0, 2'b01, tgt(1, 2, 5, 1), tgt(1, 2, 2, 1));
    send(2, 0, a2);
    send(5, 0, a5);
    send(7, 0, a7);
    chk_quiet("R6 producer firing");
    tick();
    chk_quiet("R6 local destinations not sent");
    tick();
    chk_msg("R3 lowest slot first", 3, 3, 1, 0, a2 + a7);
    tick();
    chk_msg("R3 next slot after", 4, 4, 2, 1, a5 - a7);
    // R8: fired slot stays retired in block mode
    send(2, 0, 32'h1111);
    send(2, 1, 32'h2222);
    tick();
    chk_quiet("R8 no second firing");
    do_flush();

    // R9: resident mode re-arms
    resident = 1'b1;
    a = $urandom; b = $urandom;
    load(3, 4, 2'b11, tgt(0, 5, 6, 1), '0);
    send(3, 0, a); send(3, 1, b);
    tick();
    chk_msg("R9 first iteration", 0, 5, 6, 1, a ^ b);
    a2 = $urandom; v = $urandom;
    send(3, 0, a2);
    tick();
    chk_quiet("R9 flags cleared after fire");
    send(3, 1, v);
    tick();
    chk_msg("R9 second iteration", 0, 5, 6, 1, a2 ^ v);
    resident = 1'b0;
    tick();
    do_flush();

    // R7 R5: stall holds the message, two remote destinations in order
    res_ready = 1'b0;
    a = $urandom; b = $urandom;
    load(0, 3, 2'b01, tgt(0, 1, 3, 0), tgt(6, 6, 4, 1));
    load(1, 1, 2'b01, tgt(7, 0, 5, 0), '0);
    send(0, 0, a);
    send(1, 0, b);
    chk_msg("R5 destination 0 first", 0, 1, 3, 0, a);
    tick(); tick();
    chk_msg("R7 held while stalled", 0, 1, 3, 0, a);
    res_ready = 1'b1;
    tick();
    chk_msg("R5 destination 1 second", 6, 6, 4, 1, a);
    tick();
    chk_msg("R7 blocked slot issues after", 7, 0, 5, 0, b);
    tick();
    chk_quiet("R7 queue empty");
    do_flush();

    // R10: bypass and incoming operand collide
    a = $urandom; v = $urandom;
    load(4, 0, 2'b01, tgt(2, 2, 0, 0), '0);
    load(6, 0, 2'b01, tgt(1, 2, 4, 0), '0);
    send(6, 0, a);
    send(4, 0, v);
    chk(collide_err === 1'b1, "R10 collision flagged", 64'(collide_err), 64'd1);
    chk_quiet("R10 no message yet");
    tick();
    chk_msg("R10 bypass value kept", 2, 2, 0, 0, a);
    chk(collide_err === 1'b0, "R10 flag one cycle", 64'(collide_err), 64'd0);
    tick();
    do_flush();

    // R11: flush disarms slots and drops messages
    load(0, 0, 2'b11, tgt(0, 0, 0, 0), '0);
    send(0, 0, 32'd5);
    do_flush();
    send(0, 1, 32'd6);
    tick();
    chk_quiet("R11 flushed slot does not fire");
    res_ready = 1'b0;
    load(1, 0, 2'b01, tgt(5, 5, 1, 1), '0);
    send(1, 0, 32'h77);
    tick();
    chk_msg("R11 pending before flush", 5, 5, 1, 1, 32'h77);
    do_flush();
    chk_quiet("R11 pending dropped");
    res_ready = 1'b1;
    // R1: reload after flush works from empty operand state
    load(1, 2, 2'b11, tgt(5, 5, 1, 1), '0);
    send(1, 0, 32'hF0F0);
    tick();
    chk_quiet("R1 reload holds no operands");
    send(1, 1, 32'h0FF0);
    tick();
    chk_msg("R1 reloaded slot fires", 5, 5, 1, 1, 32'h00F0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule